// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Controller

This block is the two-wire bus front end of a small serial EEPROM. It samples the raw SCL and SDA pins, cleans them with a two-flop synchronizer and a short glitch filter, and finds START and STOP conditions. It answers to one slave address and drives SDA only through an open-drain enable. A write transfer delivers a word address and then data bytes, which go one by one into an external 8-byte line latch. When the transfer closes with a STOP, a one-cycle pulse passes the byte count and the line number to the programming sequencer. The block reads back through a synchronous memory port that returns data one cycle after the request.

Writes advance only the three low address bits, so they stay inside one aligned 8-byte line. Reads advance the low eight bits and wrap inside a 256-byte page. The page bits come from the slave address and never change during a transfer. The block refuses its address while the external programming engine reports busy. If more than eight data bytes arrive, it drops the whole write. When write protect is high, it refuses data aimed at the upper half of the array.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After a START, the first byte is acknowledged only if bits 7..4 equal 1010 and bits 3..1 equal `chip_sel`, with bits that select a page excluded from the match. Bit 0 chooses read (1) or write (0). A byte that does not match gets no acknowledge.
- R2: While `busy` is high, a matching slave address gets no acknowledge.
- R3: In a write, the byte after the slave address is the word address and is acknowledged. Each accepted data byte is acknowledged and raises `wr_en` for one cycle, with `wr_idx` equal to the current address bits 2..0 and `wr_data` equal to the byte.
- R4: After each accepted data byte only address bits 2..0 increment, wrapping from 7 to 0. The line bits stay the same.
- R5: A ninth data byte and every later byte before STOP get no acknowledge and no `wr_en`. The STOP that ends such a transfer raises no `commit`.
- R6: When `wp` is high and address bit ADDR_W-1 is 1, a data byte gets no acknowledge and no `wr_en`. The slave address and the word address are still acknowledged. Lower-half bytes are still accepted.
- R7: A STOP that ends a write with 1 to 8 accepted bytes and no overflow raises `commit` for one cycle, with `commit_cnt` equal to the byte count and `commit_line` equal to address bits ADDR_W-1..3. A STOP after zero accepted bytes raises no `commit`.
- R8: A word-address write followed by a repeated START and a read address returns the byte stored at that word address, most significant bit first.
- R9: In a read, the low eight address bits increment after every byte, wrapping from 255 to 0. The block keeps sending while the master acknowledges. After a byte that the master does not acknowledge, it releases SDA.
- R10: A read that starts directly after the slave address uses the address left by the previous access.
- R11: `sda_oe` is low after reset and in idle, and it rises only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock pin level |
| sda_in | input | 1 | Raw bus data pin level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| chip_sel | input | 3 | Strapped device-select bits |
| wp | input | 1 | Write protect for the upper half |
| busy | input | 1 | Programming cycle in progress |
| wr_en | output | 1 | Line latch write strobe |
| wr_idx | output | 3 | Byte slot in the line latch |
| wr_data | output | 8 | Byte for the line latch |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| commit | output | 1 | One-cycle program request |
| commit_cnt | output | 4 | Bytes accepted in the transfer |
| commit_line | output | ADDR_W-3 | Line number to program |

## Verification
A wrong byte counter or pointer shows up within one byte time. It appears as a wrong `wr_idx` on the next latch strobe, a missing or extra acknowledge on the ninth clock, or a wrong bit on SDA in the next read byte. A wrong overflow or protect decision shows on the ninth clock of the affected byte and again as a missing or extra `commit` in the cycles right after the STOP. A state machine that is out of step with the bit counter usually shows as an acknowledge in the wrong bit slot. That slot lies within the same byte.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int ADDR_W = 8,
  parameter int FILT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        chip_sel,
  input  logic              wp,
  input  logic              busy,
  output logic              wr_en,
  output logic [2:0]        wr_idx,
  output logic [7:0]        wr_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              commit,
  output logic [3:0]        commit_cnt,
  output logic [ADDR_W-4:0] commit_line
);

  localparam int PW = ADDR_W - 8;
  localparam int MSB = ADDR_W - 1;
  localparam logic [2:0] SEL_MASK = 3'(3'b111 << PW);
  localparam logic [ADDR_W-1:0] LOW8 = ADDR_W'(8'hFF);
  localparam logic [ADDR_W-1:0] LOW3 = ADDR_W'(3'h7);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WORD, S_WDAT, S_RDAT} st_t;

  // input conditioning
  logic [1:0] scl_s, sda_s;
  logic [FILT-1:0] scl_h, sda_h;
  logic scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
      scl_h <= {scl_h[FILT-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  logic scl_re, scl_fe, start_c, stop_c;
  assign scl_re  = scl_f & ~scl_d;
  assign scl_fe  = ~scl_f & scl_d;
  assign start_c = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c  = scl_f & scl_d & ~sda_d & sda_f;

  // protocol engine
  st_t st;
  logic [3:0] bitcnt, cnt;
  logic [7:0] sh, tx, rbuf;
  logic [ADDR_W-1:0] ptr;
  logic rw, ackp, mnack, ovf, rd_q;

  logic [7:0] rx_byte;
  logic dev_hit;
  logic [ADDR_W-1:0] paged, word_ptr, winc, rinc;

  assign rx_byte  = {sh[6:0], sda_f};
  assign dev_hit  = (rx_byte[7:4] == 4'b1010) && (((rx_byte[3:1] ^ chip_sel) & SEL_MASK) == 3'b000);
  assign paged    = ADDR_W'({rx_byte[3:1], ptr[7:0]});
  assign word_ptr = (ptr & ~LOW8) | ADDR_W'(rx_byte);
  assign winc     = (ptr & ~LOW3) | ((ptr + ADDR_W'(1)) & LOW3);
  assign rinc     = (ptr & ~LOW8) | ((ptr + ADDR_W'(1)) & LOW8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bitcnt <= '0; cnt <= '0;
      sh <= '0; tx <= '0; rbuf <= '0;
      ptr <= '0;
      rw <= 1'b0; ackp <= 1'b0; mnack <= 1'b0; ovf <= 1'b0; rd_q <= 1'b0;
      sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
      rd_en <= 1'b0; rd_addr <= '0;
      commit <= 1'b0; commit_cnt <= '0; commit_line <= '0;
    end else begin
      wr_en  <= 1'b0;
      rd_en  <= 1'b0;
      commit <= 1'b0;
      rd_q   <= rd_en;
      if (rd_q) rbuf <= rd_data;

      if (start_c) begin
        st <= S_DEV; bitcnt <= '0; sda_oe <= 1'b0;
        cnt <= '0; ovf <= 1'b0; ackp <= 1'b0;
      end else if (stop_c) begin
        if (st == S_WDAT && cnt != 4'd0 && !ovf) begin
          commit      <= 1'b1;
          commit_cnt  <= cnt;
          commit_line <= ptr[MSB:3];
        end
        st <= S_IDLE; sda_oe <= 1'b0;
      end else if (st != S_IDLE && scl_re) begin
        if (bitcnt < 4'd8) begin
          sh <= rx_byte;
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            case (st)
              S_DEV: begin
                if (dev_hit && !busy) begin
                  ackp <= 1'b1;
                  rw   <= rx_byte[0];
                  ptr  <= paged;
                  if (rx_byte[0]) begin
                    rd_en <= 1'b1; rd_addr <= paged;
                  end
                end else begin
                  ackp <= 1'b0; st <= S_IDLE;
                end
              end
              S_WORD: begin
                ptr <= word_ptr; ackp <= 1'b1;
              end
              S_WDAT: begin
                if (ovf || cnt == 4'd8) begin
                  ovf <= 1'b1; ackp <= 1'b0;
                end else if (wp && ptr[MSB]) begin
                  ackp <= 1'b0;
                end else begin
                  wr_en <= 1'b1; wr_idx <= ptr[2:0]; wr_data <= rx_byte;
                  ptr <= winc; cnt <= cnt + 4'd1; ackp <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (st == S_RDAT) begin
            ptr <= rinc;
            mnack <= sda_f;
            if (!sda_f) begin
              rd_en <= 1'b1; rd_addr <= rinc;
            end
          end
        end
      end else if (st != S_IDLE && scl_fe) begin
        if (bitcnt == 4'd8) begin
          sda_oe <= (st == S_RDAT) ? 1'b0 : ackp;
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          case (st)
            S_DEV: begin
              if (rw) begin
                st <= S_RDAT; tx <= rbuf; sda_oe <= ~rbuf[7];
              end else begin
                st <= S_WORD; sda_oe <= 1'b0;
              end
            end
            S_WORD: begin st <= S_WDAT; sda_oe <= 1'b0; end
            S_RDAT: begin
              if (mnack) begin
                st <= S_IDLE; sda_oe <= 1'b0;
              end else begin
                tx <= rbuf; sda_oe <= ~rbuf[7];
              end
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (st == S_RDAT && bitcnt != 4'd0) begin
          tx <= {tx[6:0], 1'b0};
          sda_oe <= ~tx[6];
        end
      end
    end
  end

  // checks
  assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  assert_commit_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_cnt >= 4'd1 && commit_cnt <= 4'd8));

  assert_protect_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !($past(wp) && ptr[MSB]));

  assert_line_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr[MSB:3] == $past(ptr[MSB:3])));

endmodule

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
  localparam int AW = 8;
  localparam int Q  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] chip_sel = 3'b101;
  logic wp = 1'b0, busy = 1'b0;
  logic sda_oe, wr_en, rd_en, commit;
  logic [2:0] wr_idx;
  logic [7:0] wr_data, rd_data;
  logic [AW-1:0] rd_addr;
  logic [3:0] commit_cnt;
  logic [AW-4:0] commit_line;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  eeprom_i2c_slave #(.ADDR_W(AW), .FILT(3)) i_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .chip_sel(chip_sel), .wp(wp), .busy(busy),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .commit(commit), .commit_cnt(commit_cnt), .commit_line(commit_line));

  function automatic logic [7:0] pat(input logic [7:0] a);
    return (a * 8'd7) + 8'h31;
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= pat(rd_addr);

  int total = 0, bad = 0, commits = 0;
  logic [15:0] exp_wr[$];
  logic [15:0] exp_cm[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_wr.size() == 0) check(1'b0, "R3 unexpected latch write", {wr_idx, wr_data}, 0);
      else begin
        logic [15:0] e;
        e = exp_wr.pop_front();
        check(e == {5'b0, wr_idx, wr_data}, "R3/R4 latch write", {wr_idx, wr_data}, e);
      end
    end
    if (rst_n && commit) begin
      commits++;
      if (exp_cm.size() == 0) check(1'b0, "R7 unexpected commit", commit_cnt, 0);
      else begin
        logic [15:0] e;
        e = exp_cm.pop_front();
        check(e == {4'b0, commit_cnt, 3'b0, commit_line}, "R7 commit", {commit_cnt, commit_line}, e);
      end
    end
  end

  task automatic bus_start();
    wt(2); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wt(2); sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      wt(2); sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0;
    end
    wt(2); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q/2);
    acked = !sda_line;
    wt(Q/2); scl_m = 1'b0;
  endtask

  task automatic get_byte(input bit mack, output logic [7:0] b);
    b = 8'h00; sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(Q); scl_m = 1'b1; wt(Q/2); b = {b[6:0], sda_line}; wt(Q/2); scl_m = 1'b0; wt(2);
    end
    sda_m = mack ? 1'b0 : 1'b1;
    wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0; wt(2); sda_m = 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit ack;
    logic [7:0] d;
    int c0;
    wt(5); rst_n = 1'b1; wt(5);
    check(sda_oe == 1'b0, "R11 reset release", sda_oe, 0);
    check(wr_en == 1'b0 && commit == 1'b0, "R7 reset no strobe", {wr_en, commit}, 0);

    // R1: wrong select bits, wrong device code
    bus_start(); put_byte(8'hA0, ack); check(!ack, "R1 select mismatch nack", ack, 0); bus_stop();
    bus_start(); put_byte(8'h5A, ack); check(!ack, "R1 code mismatch nack", ack, 0); bus_stop();

    // R3/R7: single byte write
    bus_start(); put_byte(8'hAA, ack); check(ack, "R1 address ack", ack, 1);
    put_byte(8'h13, ack); check(ack, "R3 word ack", ack, 1);
    exp_wr.push_back({5'b0, 3'd3, 8'h77});
    exp_cm.push_back({4'b0, 4'd1, 3'b0, 5'd2});
    put_byte(8'h77, ack); check(ack, "R3 data ack", ack, 1);
    bus_stop(); wt(10);
    check(commits == 1, "R7 commit after byte write", commits, 1);

    // R4: line wrap
    bus_start(); put_byte(8'hAA, ack); put_byte(8'h2E, ack);
    for (int i = 0; i < 6; i++) begin
      exp_wr.push_back({5'b0, 3'((6 + i) % 8), 8'(8'hA0 + i)});
      put_byte(8'(8'hA0 + i), ack); check(ack, "R4 wrap data ack", ack, 1);
    end
    exp_cm.push_back({4'b0, 4'd6, 3'b0, 5'd5});
    bus_stop(); wt(10);
    check(commits == 2, "R4 commit after wrapped write", commits, 2);

    // R5: ninth byte drops transfer
    bus_start(); put_byte(8'hAA, ack); put_byte(8'h40, ack);
    for (int i = 0; i < 9; i++) begin
      if (i < 8) exp_wr.push_back({5'b0, 3'(i), 8'(8'hC0 + i)});
      put_byte(8'(8'hC0 + i), ack);
      check(ack == (i < 8), "R5 ack up to eight", ack, (i < 8));
    end
    bus_stop(); wt(10);
    check(commits == 2, "R5 no commit on overflow", commits, 2);

    // R6: write protect
    wp = 1'b1;
    bus_start(); put_byte(8'hAA, ack); check(ack, "R6 address ack under wp", ack, 1);
    put_byte(8'h90, ack); check(ack, "R6 word ack under wp", ack, 1);
    put_byte(8'h11, ack); check(!ack, "R6 upper data nack", ack, 0);
    bus_stop(); wt(10);
    check(commits == 2, "R6 no commit for protected", commits, 2);
    bus_start(); put_byte(8'hAA, ack); put_byte(8'h10, ack);
    exp_wr.push_back({5'b0, 3'd0, 8'h22});
    exp_cm.push_back({4'b0, 4'd1, 3'b0, 5'd2});
    put_byte(8'h22, ack); check(ack, "R6 lower data ack", ack, 1);
    bus_stop(); wt(10);
    wp = 1'b0;

    // R2: busy
    busy = 1'b1;
    bus_start(); put_byte(8'hAA, ack); check(!ack, "R2 busy nack", ack, 0); bus_stop();
    busy = 1'b0;

    // R8/R9: random then sequential read with wrap
    c0 = commits;
    bus_start(); put_byte(8'hAA, ack); put_byte(8'hFE, ack); check(ack, "R8 word ack", ack, 1);
    bus_start(); put_byte(8'hAB, ack); check(ack, "R8 read address ack", ack, 1);
    get_byte(1'b1, d); check(d == pat(8'hFE), "R8 random read data", d, pat(8'hFE));
    get_byte(1'b1, d); check(d == pat(8'hFF), "R9 sequential data", d, pat(8'hFF));
    get_byte(1'b0, d); check(d == pat(8'h00), "R9 wrap to zero", d, pat(8'h00));
    wt(4);
    check(sda_oe == 1'b0, "R9 release after nack", sda_oe, 0);
    bus_stop(); wt(10);
    check(commits == c0, "R7 no commit without data", commits, c0);

    // R10: current address read
    bus_start(); put_byte(8'hAB, ack); check(ack, "R10 read address ack", ack, 1);
    get_byte(1'b0, d); check(d == pat(8'h01), "R10 current address data", d, pat(8'h01));
    bus_stop(); wt(50);

    check(exp_wr.size() == 0, "R3 all latch writes seen", exp_wr.size(), 0);
    check(exp_cm.size() == 0, "R7 all commits seen", exp_cm.size(), 0);
    finish_run();
  end
endmodule